// File: doc/BRIEF.md
# SPI Slave Host Control Port

This block lets an external host trade 8-bit message bytes with an on-chip processor over a four-wire serial link. The link runs in one direction at a time. The host lowers chip select and sends an opening byte. Then it either streams bytes into the chip or clocks bytes out of it. The opening byte decides which. Bytes written by the host land in a receive queue. The processor drains that queue through a valid/ready byte interface. The processor loads bytes for the host into a transmit queue through a matching valid/ready interface.

Two side-band outputs keep the host in step. An interrupt line stays high while the transmit queue holds bytes, which tells the host to start a read. An active-low busy line tells the host to stop writing while the receive queue is almost full. All serial inputs are synchronised into the system clock and sampled there, so the whole block runs in one clock domain.

Top module: `spi_host_port`

## Requirements
- R1: SPI mode 0, MSB first, 8-bit bytes. MOSI is taken on each rising SCLK edge. In a transaction whose opening byte is 0x80, every later complete byte goes to `rx_data`/`rx_valid` in arrival order.
- R2: In a transaction whose opening byte is 0x81, MISO presents transmit-queue bytes MSB first, changing after falling SCLK edges. MOSI bits are ignored. A byte leaves the queue only when the host clocks its first bit. A trailing falling edge with no further rising edge consumes nothing.
- R3: MISO is 0 while chip select is high and throughout a write transaction.
- R4: An opening byte other than 0x80 or 0x81 makes the rest of the transaction inert. No receive byte is produced, no transmit byte is consumed, and MISO stays 0.
- R5: Raising `spi_cs_n` (active low) ends the transaction and clears the bit count. A partial byte is dropped, and the next transaction starts again with an opening byte.
- R6: `host_busy_n` is 0 while the receive queue has one free entry or fewer (occupancy of at least RX_DEPTH-1). It is 1 otherwise.
- R7: A write byte that completes while `host_busy_n` is 0 is discarded.
- R8: `host_irq` is 1 exactly while the transmit queue is non-empty.
- R9: A read byte clocked while the transmit queue is empty shifts out as 0x00 and sets `tx_underflow`. The flag stays 1 until reset.
- R10: A receive byte that is stored in the same cycle as the internal side pops the receive queue is neither lost nor duplicated.
- R11: After reset: `host_busy_n`=1, `host_irq`=0, `spi_miso`=0, `tx_underflow`=0, `rx_valid`=0, `tx_ready`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_cs_n | input | 1 | Chip select from host, active low |
| spi_sclk | input | 1 | Serial clock from host, idles low |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial data to host |
| host_irq | output | 1 | Read request to host |
| host_busy_n | output | 1 | Flow control to host, low means stop writing |
| rx_valid | output | 1 | Receive queue holds a byte |
| rx_ready | input | 1 | Internal side takes the head receive byte |
| rx_data | output | 8 | Head receive byte |
| tx_valid | input | 1 | Internal side offers a byte for the host |
| tx_ready | output | 1 | Transmit queue has room |
| tx_data | input | 8 | Byte offered for the host |
| tx_underflow | output | 1 | Sticky: host read past the transmit queue |

## Verification
Two events can fall in the same cycle on the receive queue. One is the serial side storing a completed write byte. The other is the internal side popping the head byte. The bench keeps one byte queued. It then repeats a one-byte write several times and places a single-cycle `rx_ready` pulse at a different clock offset after the last rising SCLK edge each time, so that one of the offsets coincides with the store. The check is that every pop returns the previous byte in order, and that the queue holds exactly the final byte at the end.

// File: rtl/spi_hcp_pkg.sv
package spi_hcp_pkg;

    localparam int BYTE_W = 8;

    localparam logic [BYTE_W-1:0] OPEN_WRITE = 8'h80;
    localparam logic [BYTE_W-1:0] OPEN_READ  = 8'h81;

    // Phase of the current chip-select window
    typedef enum logic [1:0] {
        PH_OPEN   = 2'd0,
        PH_WRITE  = 2'd1,
        PH_READ   = 2'd2,
        PH_IGNORE = 2'd3
    } phase_e;

    function automatic phase_e decode_open(input logic [BYTE_W-1:0] b);
        phase_e p;
        case (b)
            OPEN_WRITE: p = PH_WRITE;
            OPEN_READ:  p = PH_READ;
            default:    p = PH_IGNORE;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/spi_hcp_sync.sv
module spi_hcp_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= {STAGES{RST_VAL}};
        else     chain <= {chain[STAGES-2:0], din};
    end

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/spi_hcp_fifo.sv
module spi_hcp_fifo #(
    parameter int DEPTH = 4,
    parameter int W     = 8,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [W-1:0]  wr_data,
    input  logic          rd_en,
    output logic [W-1:0]  rd_data,
    output logic [CW-1:0] count
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic          do_wr, do_rd;

    assign do_wr = wr_en && (count != CW'(DEPTH));
    assign do_rd = rd_en && (count != '0);

    always_ff @(posedge clk) begin
        if (do_wr) mem[wr_ptr] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_wr) wr_ptr <= (wr_ptr == AW'(DEPTH-1)) ? '0 : wr_ptr + 1'b1;
            if (do_rd) rd_ptr <= (rd_ptr == AW'(DEPTH-1)) ? '0 : rd_ptr + 1'b1;
            case ({do_wr, do_rd})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    assign rd_data = mem[rd_ptr];

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (count == CW'(DEPTH)) |-> !wr_en); // R6
    AST_EMPTY_HOLDS: assert property (@(posedge clk) disable iff (rst)
        ((count == '0) && !wr_en) |=> (count == '0)); // R2
endmodule

// File: rtl/spi_hcp_frame.sv
module spi_hcp_frame
    import spi_hcp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n_s,
    input  logic              sclk_s,
    input  logic              mosi_s,
    input  logic              rx_accept,
    input  logic              tx_empty,
    input  logic [BYTE_W-1:0] tx_head,
    output logic              rx_push,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              tx_pop,
    output logic              miso,
    output logic              underflow
);
    phase_e            phase;
    logic [2:0]        bit_cnt;
    logic [BYTE_W-2:0] in_sh;
    logic [BYTE_W-1:0] out_sh;
    logic              held;
    logic              sclk_d;
    logic              active, rise, fall, first_bit;
    logic [BYTE_W-1:0] in_next;

    assign active    = !cs_n_s;
    assign rise      = sclk_s && !sclk_d;
    assign fall      = !sclk_s && sclk_d;
    assign in_next   = {in_sh, mosi_s};
    assign first_bit = active && rise && (phase == PH_READ) && (bit_cnt == 3'd0);

    assign rx_push = active && rise && (bit_cnt == 3'd7) && (phase == PH_WRITE) && rx_accept;
    assign rx_byte = in_next;
    assign tx_pop  = first_bit && held;
    assign miso    = (phase == PH_READ) && out_sh[BYTE_W-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_d    <= 1'b0;
            phase     <= PH_OPEN;
            bit_cnt   <= '0;
            in_sh     <= '0;
            out_sh    <= '0;
            held      <= 1'b0;
            underflow <= 1'b0;
        end else begin
            sclk_d <= sclk_s;
            if (first_bit && !held) underflow <= 1'b1;
            if (!active) begin
                phase   <= PH_OPEN;
                bit_cnt <= '0;
                out_sh  <= '0;
                held    <= 1'b0;
            end else begin
                if (rise) begin
                    in_sh   <= in_next[BYTE_W-2:0];
                    bit_cnt <= bit_cnt + 3'd1;
                    if (bit_cnt == 3'd7 && phase == PH_OPEN) phase <= decode_open(in_next);
                end
                if (fall && phase == PH_READ) begin
                    if (bit_cnt == 3'd0) begin
                        out_sh <= tx_empty ? '0 : tx_head;
                        held   <= !tx_empty;
                    end else begin
                        out_sh <= {out_sh[BYTE_W-2:0], 1'b0};
                    end
                end
            end
        end
    end

    AST_IGNORE_INERT: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_IGNORE) |-> (!rx_push && !tx_pop && !miso)); // R4
    AST_OPEN_NO_PUSH: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_OPEN) |-> !rx_push); // R1
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        $past(cs_n_s) |-> !miso); // R3
endmodule

// File: rtl/spi_host_port.sv
module spi_host_port
    import spi_hcp_pkg::*;
#(
    parameter int RX_DEPTH    = 4,
    parameter int TX_DEPTH    = 4,
    parameter int SYNC_STAGES = 2,
    localparam int RX_CW      = $clog2(RX_DEPTH + 1),
    localparam int TX_CW      = $clog2(TX_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              spi_cs_n,
    input  logic              spi_sclk,
    input  logic              spi_mosi,
    output logic              spi_miso,
    output logic              host_irq,
    output logic              host_busy_n,
    output logic              rx_valid,
    input  logic              rx_ready,
    output logic [BYTE_W-1:0] rx_data,
    input  logic              tx_valid,
    output logic              tx_ready,
    input  logic [BYTE_W-1:0] tx_data,
    output logic              tx_underflow
);
    logic              cs_n_s, sclk_s, mosi_s;
    logic              rx_push, tx_pop;
    logic [BYTE_W-1:0] rx_byte, tx_head;
    logic [RX_CW-1:0]  rx_count;
    logic [TX_CW-1:0]  tx_count;
    logic              tx_empty;

    spi_hcp_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_cs (
        .clk(clk), .rst(rst), .din(spi_cs_n), .dout(cs_n_s));
    spi_hcp_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sclk (
        .clk(clk), .rst(rst), .din(spi_sclk), .dout(sclk_s));
    spi_hcp_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_mosi (
        .clk(clk), .rst(rst), .din(spi_mosi), .dout(mosi_s));

    spi_hcp_frame u_frame (
        .clk(clk), .rst(rst),
        .cs_n_s(cs_n_s), .sclk_s(sclk_s), .mosi_s(mosi_s),
        .rx_accept(host_busy_n), .tx_empty(tx_empty), .tx_head(tx_head),
        .rx_push(rx_push), .rx_byte(rx_byte), .tx_pop(tx_pop),
        .miso(spi_miso), .underflow(tx_underflow));

    spi_hcp_fifo #(.DEPTH(RX_DEPTH), .W(BYTE_W)) u_rx_q (
        .clk(clk), .rst(rst),
        .wr_en(rx_push), .wr_data(rx_byte),
        .rd_en(rx_ready), .rd_data(rx_data), .count(rx_count));

    spi_hcp_fifo #(.DEPTH(TX_DEPTH), .W(BYTE_W)) u_tx_q (
        .clk(clk), .rst(rst),
        .wr_en(tx_valid && tx_ready), .wr_data(tx_data),
        .rd_en(tx_pop), .rd_data(tx_head), .count(tx_count));

    assign rx_valid    = (rx_count != '0);
    assign host_busy_n = (rx_count < RX_CW'(RX_DEPTH - 1));
    assign tx_empty    = (tx_count == '0);
    assign tx_ready    = (tx_count != TX_CW'(TX_DEPTH));
    assign host_irq    = !tx_empty;

    AST_BUSY_BLOCKS_PUSH: assert property (@(posedge clk) disable iff (rst)
        !host_busy_n |-> !rx_push); // R7
    AST_IRQ_FALLS_ON_POP: assert property (@(posedge clk) disable iff (rst)
        $fell(host_irq) |-> $past(tx_pop)); // R8
    AST_UNDERFLOW_STICKY: assert property (@(posedge clk) disable iff (rst)
        $past(tx_underflow) |-> tx_underflow); // R9
endmodule

// File: tb/spi_host_port_tb_top.sv
module spi_host_port_tb_top;
    localparam int HALF = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       spi_cs_n = 1'b1, spi_sclk = 1'b0, spi_mosi = 1'b0;
    logic       spi_miso, host_irq, host_busy_n, rx_valid, tx_ready, tx_underflow;
    logic       rx_ready = 1'b0, tx_valid = 1'b0;
    logic [7:0] rx_data, tx_data = 8'h00;

    logic [7:0] mo [16];
    logic [7:0] mi [16];
    int vectors = 0;
    int errors  = 0;

    always #2 clk = ~clk;

    spi_host_port dut_i (
        .clk(clk), .rst(rst), .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso), .host_irq(host_irq),
        .host_busy_n(host_busy_n), .rx_valid(rx_valid), .rx_ready(rx_ready),
        .rx_data(rx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .tx_data(tx_data), .tx_underflow(tx_underflow));

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic spi_bits(input int nbits);
        spi_cs_n = 1'b0;
        wait_clk(HALF);
        for (int k = 0; k < nbits; k++) begin
            spi_mosi = mo[k/8][7-(k%8)];
            wait_clk(HALF);
            mi[k/8][7-(k%8)] = spi_miso;
            spi_sclk = 1'b1;
            wait_clk(HALF);
            spi_sclk = 1'b0;
        end
        wait_clk(HALF);
        spi_cs_n = 1'b1;
        spi_mosi = 1'b0;
        wait_clk(3*HALF);
    endtask

    task automatic pop_expect(input string req, input logic [7:0] exp);
        @(negedge clk);
        check(req, "rx_valid", rx_valid, 1);
        check(req, "rx_data", rx_data, exp);
        rx_ready = 1'b1;
        @(negedge clk);
        rx_ready = 1'b0;
    endtask

    task automatic push_tx(input logic [7:0] b);
        @(negedge clk);
        tx_valid = 1'b1;
        tx_data  = b;
        @(negedge clk);
        tx_valid = 1'b0;
    endtask

    task automatic t_reset;
        @(negedge clk);
        check("R11", "busy_n", host_busy_n, 1);
        check("R11", "irq", host_irq, 0);
        check("R11", "miso", spi_miso, 0);
        check("R11", "underflow", tx_underflow, 0);
        check("R11", "rx_valid", rx_valid, 0);
        check("R11", "tx_ready", tx_ready, 1);
    endtask

    task automatic t_write;
        mo[0] = 8'h80; mo[1] = 8'hA5; mo[2] = 8'h3C;
        spi_bits(24);
        check("R3", "miso during write", {mi[0], mi[1], mi[2]}, 24'h0);
        pop_expect("R1", 8'hA5);
        pop_expect("R1", 8'h3C);
        @(negedge clk);
        check("R1", "rx drained", rx_valid, 0);
    endtask

    task automatic t_read;
        push_tx(8'h5A);
        push_tx(8'hC3);
        @(negedge clk);
        check("R8", "irq with data", host_irq, 1);
        mo[0] = 8'h81; mo[1] = 8'hFF; mo[2] = 8'hFF;
        spi_bits(24);
        check("R3", "miso during opening byte", mi[0], 0);
        check("R2", "read byte 1", mi[1], 8'h5A);
        check("R2", "read byte 2", mi[2], 8'hC3);
        check("R8", "irq after drain", host_irq, 0);
        check("R2", "mosi ignored in read", rx_valid, 0);
        check("R9", "no underflow", tx_underflow, 0);
    endtask

    task automatic t_bad_open;
        push_tx(8'h77);
        mo[0] = 8'h42; mo[1] = 8'h11; mo[2] = 8'h22;
        spi_bits(24);
        check("R4", "miso quiet", {mi[0], mi[1], mi[2]}, 24'h0);
        check("R4", "no rx byte", rx_valid, 0);
        check("R4", "tx untouched", host_irq, 1);
    endtask

    task automatic t_cs_abort;
        mo[0] = 8'h80;
        spi_bits(5);
        mo[0] = 8'h80; mo[1] = 8'h99;
        spi_bits(16);
        pop_expect("R5", 8'h99);
        @(negedge clk);
        check("R5", "only one byte", rx_valid, 0);
        check("R5", "tx untouched", host_irq, 1);
    endtask

    task automatic t_read_tail;
        push_tx(8'h88);
        mo[0] = 8'h81; mo[1] = 8'h00;
        spi_bits(16);
        check("R2", "first of two", mi[1], 8'h77);
        check("R2", "tail fall pops nothing", host_irq, 1);
        spi_bits(16);
        check("R2", "second of two", mi[1], 8'h88);
        check("R8", "irq cleared", host_irq, 0);
        check("R9", "no underflow", tx_underflow, 0);
    endtask

    task automatic t_busy;
        mo[0] = 8'h80; mo[1] = 8'h01; mo[2] = 8'h02;
        spi_bits(24);
        check("R6", "busy_n at two stored", host_busy_n, 1);
        mo[0] = 8'h80; mo[1] = 8'h03; mo[2] = 8'h04; mo[3] = 8'h05;
        spi_bits(32);
        check("R6", "busy_n at three stored", host_busy_n, 0);
        pop_expect("R7", 8'h01);
        @(negedge clk);
        check("R6", "busy_n released", host_busy_n, 1);
        pop_expect("R7", 8'h02);
        pop_expect("R7", 8'h03);
        @(negedge clk);
        check("R7", "late bytes discarded", rx_valid, 0);
    endtask

    task automatic t_underflow;
        push_tx(8'hE7);
        mo[0] = 8'h81; mo[1] = 8'h00; mo[2] = 8'h00;
        spi_bits(24);
        check("R9", "last real byte", mi[1], 8'hE7);
        check("R9", "past end is zero", mi[2], 8'h00);
        check("R9", "flag set", tx_underflow, 1);
        mo[0] = 8'h80; mo[1] = 8'h5E;
        spi_bits(16);
        check("R9", "flag sticky", tx_underflow, 1);
        pop_expect("R9", 8'h5E);
    endtask

    task automatic t_same_cycle;
        logic [7:0] prev;
        mo[0] = 8'h80; mo[1] = 8'h10;
        spi_bits(16);
        prev = 8'h10;
        for (int off = 0; off < 7; off++) begin
            mo[0] = 8'h80; mo[1] = 8'h20 + 8'(off);
            fork
                spi_bits(16);
                begin
                    for (int i = 0; i < 16; i++) @(posedge spi_sclk);
                    repeat (off) @(posedge clk);
                    @(negedge clk);
                    check("R10", "rx_valid at pop", rx_valid, 1);
                    check("R10", "popped byte", rx_data, prev);
                    rx_ready = 1'b1;
                    @(negedge clk);
                    rx_ready = 1'b0;
                end
            join
            prev = 8'h20 + 8'(off);
        end
        pop_expect("R10", 8'h26);
        @(negedge clk);
        check("R10", "queue empty", rx_valid, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        vectors++;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        wait_clk(4);
        rst = 1'b0;
        t_reset();
        t_write();
        t_read();
        t_bad_open();
        t_cs_abort();
        t_read_tail();
        t_busy();
        t_underflow();
        t_same_cycle();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule